// File: doc/BRIEF.md
# UART Automatic Hardware Flow Control

This block throttles a serial link with a pair of active-low handshake lines. On the receive side it compares the receive FIFO fill level against two programmable thresholds. When the fill reaches the upper mark it drives the local request-to-send line high (inactive), which tells the far transmitter to stop. It drives the line low (active) again only after the fill has fallen to the lower mark, so the line has hysteresis. A third, independent level raises the receive data-ready interrupt. Bytes that arrive while the request line is inactive are still accepted while the FIFO has room. A byte pushed into a full FIFO sets a sticky overrun flag.

On the transmit side the incoming clear-to-send pin passes through a two-flop synchronizer. The synchronized value produces a transmit-enable, which the transmitter samples only when it is about to load a new character. A character already in the shift register therefore always completes, and the link pauses at the next character boundary. Each automatic function has its own enable. With automatic request disabled, the request line follows a software bit. With automatic clear disabled, the transmitter ignores the pin. Two instances wired back to back, each request line feeding the other side's clear line, control both directions of a link.

Top module: `uart_flow_ctl`

## Requirements
- R1: `rx_irq` is high in the cycle after a clock edge at which `rx_level >= trig_lvl`, and low in the cycle after an edge at which `rx_level < trig_lvl`. The interrupt does not affect reception or `rts_n`.
- R2: With `auto_rts_en` high, `rts_n` is 1 (inactive) in the cycle after an edge at which `rx_level >= thr_hi`.
- R3: With `auto_rts_en` high, `rts_n` becomes 0 (active) after an edge at which `rx_level <= thr_lo` and `rx_level < thr_hi`. When `thr_lo < rx_level < thr_hi`, `rts_n` keeps its previous value.
- R4: The upper comparison has priority over the lower one. With `thr_lo == thr_hi`, the block acts as a single-threshold comparator: `rts_n` is 1 at or above the threshold and 0 below it.
- R5: With `auto_rts_en` low, `rts_n` equals the inverse of `sw_rts` registered one cycle earlier, whatever the fill level.
- R6: With `auto_cts_en` high, `tx_en` equals the inverse of the `cts_n` value present three clock edges earlier: two synchronizer flops plus the output register. The transmitter samples `tx_en` only when it loads a character, so a character in flight always finishes.
- R7: With `auto_cts_en` low, `tx_en` is 1 one edge later, whatever `cts_n` does.
- R8: `overrun` is set by an edge at which `rx_push` is high and `rx_level == DEPTH`. It is cleared by an edge at which `ovr_clr` is high and no such push occurs; setting wins over clearing. The flag holds its value otherwise.
- R9: While `rst` is high, the outputs are `rts_n = 1`, `rx_irq = 0`, `tx_en = 0` and `overrun = 0`, and both synchronizer flops hold 1 (inactive).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_level | input | LW | Receive FIFO fill level, 0..DEPTH |
| rx_push | input | 1 | A received byte is written this cycle |
| thr_hi | input | LW | Upper fill threshold (request goes inactive) |
| thr_lo | input | LW | Lower fill threshold (request goes active) |
| trig_lvl | input | LW | Data-ready interrupt level |
| auto_rts_en | input | 1 | Enable automatic request control |
| sw_rts | input | 1 | Software request bit, 1 = request active |
| auto_cts_en | input | 1 | Enable automatic transmit gating |
| cts_n | input | 1 | Asynchronous clear-to-send pin, active low |
| ovr_clr | input | 1 | Clear the overrun flag |
| rts_n | output | 1 | Request-to-send pin, active low |
| rx_irq | output | 1 | Receive data-ready interrupt |
| tx_en | output | 1 | Transmitter may load a new character |
| overrun | output | 1 | Sticky overrun flag |

## Verification
The hardest state to reach is the hold band of R3. There, the fill level sits strictly between the thresholds, and the required `rts_n` depends on whether the level last came down from the upper mark or up from the lower one. The stimulus reaches it by moving the fill level in a random walk of single steps, so it crosses each threshold from both sides and lingers between them. Directed phases add equal thresholds, a push into a full FIFO in the same cycle as a clear, and clear-to-send pulses timed against the three-edge delay.

// File: rtl/uart_flow_pkg.sv
package uart_flow_pkg;
  // Decision of the hysteresis comparator for one cycle
  typedef enum logic [1:0] {
    FC_HOLD  = 2'd0,
    FC_STOP  = 2'd1,
    FC_START = 2'd2
  } fc_cmd_e;
endpackage

// File: rtl/uart_fc_sync.sv
module uart_fc_sync #(
  parameter int STAGES = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{RST_VAL}};
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/uart_fc_rts.sv
module uart_fc_rts
  import uart_flow_pkg::*;
#(
  parameter int LW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [LW-1:0] level,
  input  logic [LW-1:0] thr_hi,
  input  logic [LW-1:0] thr_lo,
  input  logic          auto_en,
  input  logic          sw_req,
  output logic          rts_n
);
  fc_cmd_e cmd;

  // upper mark checked first, so equal thresholds give one comparator
  always_comb begin
    if (level >= thr_hi)      cmd = FC_STOP;
    else if (level <= thr_lo) cmd = FC_START;
    else                      cmd = FC_HOLD;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rts_n <= 1'b1;
    end else if (!auto_en) begin
      rts_n <= ~sw_req;
    end else begin
      case (cmd)
        FC_STOP:  rts_n <= 1'b1;
        FC_START: rts_n <= 1'b0;
        default:  rts_n <= rts_n;
      endcase
    end
  end
endmodule

// File: rtl/uart_fc_txgate.sv
module uart_fc_txgate #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cts_n,
  input  logic auto_en,
  output logic tx_en
);
  logic cts_n_s;

  uart_fc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (cts_n),
    .q   (cts_n_s)
  );

  // tx_en is sampled only at character load, so a frame in flight completes
  always_ff @(posedge clk) begin
    if (rst) tx_en <= 1'b0;
    else     tx_en <= ~auto_en | ~cts_n_s;
  end
endmodule

// File: rtl/uart_flow_ctl.sv
module uart_flow_ctl #(
  parameter int DEPTH = 16,
  parameter int SYNC_STAGES = 2,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [LW-1:0] rx_level,
  input  logic          rx_push,
  input  logic [LW-1:0] thr_hi,
  input  logic [LW-1:0] thr_lo,
  input  logic [LW-1:0] trig_lvl,
  input  logic          auto_rts_en,
  input  logic          sw_rts,
  input  logic          auto_cts_en,
  input  logic          cts_n,
  input  logic          ovr_clr,
  output logic          rts_n,
  output logic          rx_irq,
  output logic          tx_en,
  output logic          overrun
);
  localparam logic [LW-1:0] FULL = LW'(DEPTH);

  uart_fc_rts #(.LW(LW)) u_rts (
    .clk     (clk),
    .rst     (rst),
    .level   (rx_level),
    .thr_hi  (thr_hi),
    .thr_lo  (thr_lo),
    .auto_en (auto_rts_en),
    .sw_req  (sw_rts),
    .rts_n   (rts_n)
  );

  uart_fc_txgate #(.SYNC_STAGES(SYNC_STAGES)) u_tx (
    .clk     (clk),
    .rst     (rst),
    .cts_n   (cts_n),
    .auto_en (auto_cts_en),
    .tx_en   (tx_en)
  );

  logic push_full;
  assign push_full = rx_push && (rx_level == FULL);

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_irq  <= 1'b0;
      overrun <= 1'b0;
    end else begin
      rx_irq <= (rx_level >= trig_lvl);
      if (push_full)    overrun <= 1'b1;
      else if (ovr_clr) overrun <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_flow_ctl_chk.sv
module uart_flow_ctl_chk #(
  parameter int DEPTH = 16,
  parameter int LW = 5
) (
  input logic          clk,
  input logic          rst,
  input logic [LW-1:0] rx_level,
  input logic          rx_push,
  input logic [LW-1:0] thr_hi,
  input logic [LW-1:0] thr_lo,
  input logic [LW-1:0] trig_lvl,
  input logic          auto_rts_en,
  input logic          sw_rts,
  input logic          auto_cts_en,
  input logic          ovr_clr,
  input logic          rts_n,
  input logic          rx_irq,
  input logic          tx_en,
  input logic          overrun
);
  p_irq_set_r1: assert property (@(posedge clk) disable iff (rst)
    (rx_level >= trig_lvl) |=> rx_irq);
  p_irq_clr_r1: assert property (@(posedge clk) disable iff (rst)
    (rx_level < trig_lvl) |=> !rx_irq);
  p_rts_stop_r2: assert property (@(posedge clk) disable iff (rst)
    (auto_rts_en && rx_level >= thr_hi) |=> rts_n);
  p_rts_start_r3: assert property (@(posedge clk) disable iff (rst)
    (auto_rts_en && rx_level <= thr_lo && rx_level < thr_hi) |=> !rts_n);
  p_rts_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (auto_rts_en && rx_level > thr_lo && rx_level < thr_hi) |=> $stable(rts_n));
  p_rts_sw_r5: assert property (@(posedge clk) disable iff (rst)
    (!auto_rts_en) |=> (rts_n == !$past(sw_rts)));
  p_tx_free_r7: assert property (@(posedge clk) disable iff (rst)
    (!auto_cts_en) |=> tx_en);
  p_ovr_set_r8: assert property (@(posedge clk) disable iff (rst)
    (rx_push && rx_level == LW'(DEPTH)) |=> overrun);
  p_ovr_clr_r8: assert property (@(posedge clk) disable iff (rst)
    (ovr_clr && !(rx_push && rx_level == LW'(DEPTH))) |=> !overrun);
endmodule

bind uart_flow_ctl uart_flow_ctl_chk #(.DEPTH(DEPTH), .LW(LW)) u_chk (
  .clk(clk), .rst(rst), .rx_level(rx_level), .rx_push(rx_push),
  .thr_hi(thr_hi), .thr_lo(thr_lo), .trig_lvl(trig_lvl),
  .auto_rts_en(auto_rts_en), .sw_rts(sw_rts), .auto_cts_en(auto_cts_en),
  .ovr_clr(ovr_clr), .rts_n(rts_n), .rx_irq(rx_irq), .tx_en(tx_en),
  .overrun(overrun)
);

// File: tb/uart_flow_ctl_bench.sv
module uart_flow_ctl_bench;
  localparam int DEPTH = 16;
  localparam int LW = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [LW-1:0] rx_level = '0, thr_hi = LW'(12), thr_lo = LW'(4), trig_lvl = LW'(8);
  logic rx_push = 0, auto_rts_en = 1, sw_rts = 0, auto_cts_en = 1, cts_n = 1, ovr_clr = 0;
  logic rts_n, rx_irq, tx_en, overrun;

  always #4 clk = ~clk;

  uart_flow_ctl #(.DEPTH(DEPTH)) u_uart_flow_ctl (
    .clk(clk), .rst(rst), .rx_level(rx_level), .rx_push(rx_push),
    .thr_hi(thr_hi), .thr_lo(thr_lo), .trig_lvl(trig_lvl),
    .auto_rts_en(auto_rts_en), .sw_rts(sw_rts), .auto_cts_en(auto_cts_en),
    .cts_n(cts_n), .ovr_clr(ovr_clr), .rts_n(rts_n), .rx_irq(rx_irq),
    .tx_en(tx_en), .overrun(overrun)
  );

  int n_chk = 0, n_bad = 0, cyc = 0;
  logic e_rts = 1, e_irq = 0, e_tx = 0, e_ovr = 0;
  logic [2:0] cts_hist = 3'b111;   // cts_n at the last three edges, [2] oldest

  // expected next request line from the requirements
  function automatic logic f_rts(logic cur, logic aut, logic sw,
                                 logic [LW-1:0] lv, logic [LW-1:0] hi, logic [LW-1:0] lo);
    if (!aut) return ~sw;          // R5
    if (lv >= hi) return 1'b1;     // R2, R4
    if (lv <= lo) return 1'b0;     // R3
    return cur;                    // R3 hold band
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst) begin
      e_rts <= 1; e_irq <= 0; e_tx <= 0; e_ovr <= 0; cts_hist <= 3'b111;
    end else begin
      e_rts <= f_rts(e_rts, auto_rts_en, sw_rts, rx_level, thr_hi, thr_lo);
      e_irq <= (rx_level >= trig_lvl);
      cts_hist <= {cts_hist[1:0], cts_n};
      e_tx  <= !auto_cts_en || !cts_hist[1];   // R6 / R7
      if (rx_push && rx_level == LW'(DEPTH)) e_ovr <= 1;
      else if (ovr_clr) e_ovr <= 0;
    end
  end

  task automatic chk(string tag, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s cycle %0d: actual %b expected %b", tag, cyc, act, exp);
    end
  endtask

  task automatic cmp_all();
    chk("R2 R3 R4 R5 rts_n", rts_n, e_rts);
    chk("R1 rx_irq", rx_irq, e_irq);
    chk("R6 R7 tx_en", tx_en, e_tx);
    chk("R8 overrun", overrun, e_ovr);
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk); cmp_all();
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R9 reset rts_n", rts_n, 1'b1);
    chk("R9 reset rx_irq", rx_irq, 1'b0);
    chk("R9 reset tx_en", tx_en, 1'b0);
    chk("R9 reset overrun", overrun, 1'b0);
    rst = 0;
    step();
    // directed: equal thresholds, single comparator (R4)
    thr_hi = 6; thr_lo = 6;
    rx_level = 6; step(); chk("R4 at equal thr", rts_n, 1'b1);
    rx_level = 5; step(); chk("R4 below equal thr", rts_n, 1'b0);
    // directed: hysteresis hold band (R3)
    thr_hi = 10; thr_lo = 3;
    rx_level = 10; step(); rx_level = 7; step(); chk("R3 hold high", rts_n, 1'b1);
    rx_level = 3;  step(); rx_level = 7; step(); chk("R3 hold low", rts_n, 1'b0);
    // directed: push into full with clear in same cycle (R8)
    rx_level = LW'(DEPTH); rx_push = 1; ovr_clr = 1; step();
    chk("R8 set wins", overrun, 1'b1);
    rx_push = 0; step(); chk("R8 cleared", overrun, 1'b0);
    ovr_clr = 0;
    // directed: cts_n delay of three edges (R6)
    cts_n = 0; step(); step(); chk("R6 not yet", tx_en, 1'b0);
    step(); chk("R6 after three edges", tx_en, 1'b1);
    auto_cts_en = 0; cts_n = 1; step(); chk("R7 ignores cts", tx_en, 1'b1);
    auto_cts_en = 1;
    // random phase
    for (int i = 0; i < 6000; i++) begin
      if (i % 300 == 0) begin
        thr_hi = LW'($urandom_range(DEPTH, 1));
        thr_lo = LW'($urandom_range(thr_hi, 0));
        trig_lvl = LW'($urandom_range(DEPTH, 0));
        auto_rts_en = ($urandom_range(3, 0) != 0);
        auto_cts_en = ($urandom_range(3, 0) != 0);
      end
      case ($urandom_range(2, 0))
        0: if (rx_level > 0) rx_level = rx_level - 1;
        1: if (rx_level < LW'(DEPTH)) rx_level = rx_level + 1;
        default: ;
      endcase
      rx_push = $urandom_range(1, 0);
      ovr_clr = ($urandom_range(15, 0) == 0);
      sw_rts  = $urandom_range(1, 0);
      if ($urandom_range(7, 0) == 0) cts_n = ~cts_n;
      step();
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #800000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule